// File: doc/BRIEF.md
# Oscillator Wake-Up Sequencer

This block brings a subsystem back from its deepest power-down state, where the crystal oscillator itself has been stopped. Four wake sources can start it: a hardware reset request, a USB reset or resume, a real-time-clock interrupt and an external interrupt. A source only counts once it has been held long enough. After that the sequencer starts the oscillator, turns on the secondary (USB) PLL and waits for that PLL to lock. External interrupts stay masked for that whole wait, because the secondary PLL acts as the timekeeper that proves the oscillator has stabilized.

Once the secondary lock arrives, the sequencer unmasks interrupts and pulses a clear of the pending idle configuration. In the following cycle it releases the main clock generator and enables the main PLL. When the main PLL reports lock, the sequencer counts a settle interval of about one millisecond on the always-running bypass clock. Only then does it move the system clock select from bypass to the PLL output and restore the CPU domain. If lock drops during the settle interval, the count restarts. The analog oscillator and both PLLs are outside the block and appear only as ready and lock inputs.

Top module: `osc_wake_seq`

## Requirements
- R1: While asleep, a wake source counts only when at least one of the four wake inputs stays high for MIN_WAKE_CYC consecutive clock edges. `osc_en` rises in the cycle after the last of those edges. A shorter pulse leaves every output unchanged.
- R2: After reset and while asleep, `irq_mask` is 1 and every other output is 0.
- R3: `usb_pll_en` rises in the cycle after `osc_ready` is sampled high with `osc_en` asserted. Until then it stays 0.
- R4: `irq_mask` stays 1 until `usb_pll_lock` is sampled high after `usb_pll_en` was raised. If that lock never arrives, the mask never clears and the main PLL is never enabled.
- R5: In the cycle after the secondary lock is sampled, `irq_mask` falls and `idle_cfg_clr` is high for exactly one cycle. `main_pll_en` and `restore_clkgen` rise in the cycle after that pulse.
- R6: `clk_sel_pll` (1 = PLL output, 0 = bypass) and `restore_cpu` rise together, and only after the settle interval completes with the main PLL locked. No domain other than clock generation and CPU is signalled for restore.
- R7: If `main_pll_lock` goes low during the settle interval, the sequencer goes back to waiting for lock, keeps `clk_sel_pll` at 0, and restarts the full settle count when lock returns.
- R8: With the sequencer running, a one-cycle `sleep_req` returns every output to its sleep value (see R2) in the next cycle.
- R9: The settle length SETTLE_CYC equals BYPASS_KHZ*SETTLE_US/1000 bypass cycles. Take the first edge at which the main PLL lock is sampled with `main_pll_en` high. `clk_sel_pll` rises SETTLE_CYC edges after that edge.
- R10: Wake inputs have no effect unless the sequencer is asleep. A wake held while running leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running bypass clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wake_hw_reset | input | 1 | Hardware reset wake request |
| wake_usb_resume | input | 1 | USB reset/resume wake request |
| wake_rtc_irq | input | 1 | Real-time-clock interrupt wake request |
| wake_ext_irq | input | 1 | External interrupt wake request |
| osc_ready | input | 1 | Oscillator running indication |
| usb_pll_lock | input | 1 | Secondary (USB) PLL lock |
| main_pll_lock | input | 1 | Main PLL lock |
| sleep_req | input | 1 | Request to re-enter full power-down |
| osc_en | output | 1 | Oscillator enable |
| usb_pll_en | output | 1 | Secondary PLL enable |
| main_pll_en | output | 1 | Main PLL enable |
| irq_mask | output | 1 | External interrupt mask, 1 = masked |
| clk_sel_pll | output | 1 | System clock select, 1 = PLL, 0 = bypass |
| idle_cfg_clr | output | 1 | One-cycle clear of the pending idle configuration |
| restore_clkgen | output | 1 | Clock-generation domain restored |
| restore_cpu | output | 1 | CPU domain restored |

## Verification
The assertions assume that the lock and ready inputs behave like real analog status. A lock that appears before its enable is simply ignored. The main lock may be dropped and raised again during settle without any other constraint. The properties on unmasking, the enable ordering and the clock switch relate each output edge to the input value sampled one edge earlier. The stimulus drives every input at the falling clock edge, raises each lock only after its enable is visible, and pulses `sleep_req` only while running. It also covers a lock that never arrives, a wake pulse just below the qualifying length, and a lock drop in the middle of the settle count.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

    localparam int NUM_WAKE_SRC = 4;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_OSC_START,
        ST_USB_LOCK_WAIT,
        ST_MAIN_LOCK_WAIT,
        ST_SETTLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       osc_en;
        logic       usb_pll_en;
        logic       main_pll_en;
        logic       irq_mask;
        logic       clk_sel_pll;
        logic       idle_cfg_clr;
        logic       restore_clkgen;
        logic       restore_cpu;
    } seq_regs_t;

    localparam seq_regs_t SEQ_ASLEEP = '{
        state:          ST_SLEEP,
        osc_en:         1'b0,
        usb_pll_en:     1'b0,
        main_pll_en:    1'b0,
        irq_mask:       1'b1,
        clk_sel_pll:    1'b0,
        idle_cfg_clr:   1'b0,
        restore_clkgen: 1'b0,
        restore_cpu:    1'b0
    };

endpackage

// File: rtl/osc_wake_filter.sv
module osc_wake_filter #(
    parameter int MIN_WAKE_CYC = 16,
    parameter int NUM_SRC      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [NUM_SRC-1:0] src,
    output logic               qualified
);
    localparam int HOLD = (MIN_WAKE_CYC < 1) ? 1 : MIN_WAKE_CYC;
    localparam int CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          any_src;

    always_comb begin
        any_src   = |src;
        qualified = arm && any_src && (cnt_q == LIM);
        if (arm && any_src) begin
            cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the hold counter saturates at its limit
    a_r1_hold_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R1: the count only grows while a source is held and the filter is armed
    a_r1_count_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !$past(cnt_q == LIM)) |-> $past(arm && any_src));

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int TERM = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int LEN = (TERM < 1) ? 1 : TERM;
    localparam int CW  = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done = run && (cnt_q == LAST);
        if (run && !done) cnt_d = cnt_q + 1'b1;
        else              cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: the settle count never runs past its terminal value
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: a pause in the run qualifier restarts the count from zero
    a_r7_restart_on_pause: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/osc_wake_seq.sv
module osc_wake_seq
    import osc_wake_pkg::*;
#(
    parameter int MIN_WAKE_CYC = 16,
    parameter int BYPASS_KHZ   = 12000,
    parameter int SETTLE_US    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_hw_reset,
    input  logic wake_usb_resume,
    input  logic wake_rtc_irq,
    input  logic wake_ext_irq,
    input  logic osc_ready,
    input  logic usb_pll_lock,
    input  logic main_pll_lock,
    input  logic sleep_req,
    output logic osc_en,
    output logic usb_pll_en,
    output logic main_pll_en,
    output logic irq_mask,
    output logic clk_sel_pll,
    output logic idle_cfg_clr,
    output logic restore_clkgen,
    output logic restore_cpu
);
    localparam int SETTLE_RAW = (BYPASS_KHZ * SETTLE_US) / 1000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    seq_regs_t                 r_d, r_q;
    logic [NUM_WAKE_SRC-1:0]   wake_vec;
    logic                      wake_ok;
    logic                      settle_run;
    logic                      settle_done;

    assign wake_vec = {wake_ext_irq, wake_rtc_irq, wake_usb_resume, wake_hw_reset};

    osc_wake_filter #(
        .MIN_WAKE_CYC (MIN_WAKE_CYC),
        .NUM_SRC      (NUM_WAKE_SRC)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (r_q.state == ST_SLEEP),
        .src       (wake_vec),
        .qualified (wake_ok)
    );

    assign settle_run = (r_q.state == ST_SETTLE) && main_pll_lock;

    osc_settle_timer #(
        .TERM (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    always_comb begin
        r_d              = r_q;
        r_d.idle_cfg_clr = 1'b0;
        unique case (r_q.state)
            ST_SLEEP: begin
                if (wake_ok) begin
                    r_d.state  = ST_OSC_START;
                    r_d.osc_en = 1'b1;
                end
            end
            ST_OSC_START: begin
                if (osc_ready) begin
                    r_d.state      = ST_USB_LOCK_WAIT;
                    r_d.usb_pll_en = 1'b1;
                end
            end
            ST_USB_LOCK_WAIT: begin
                if (usb_pll_lock) begin
                    r_d.state        = ST_MAIN_LOCK_WAIT;
                    r_d.irq_mask     = 1'b0;
                    r_d.idle_cfg_clr = 1'b1;
                end
            end
            ST_MAIN_LOCK_WAIT: begin
                if (r_q.idle_cfg_clr) begin
                    r_d.main_pll_en    = 1'b1;
                    r_d.restore_clkgen = 1'b1;
                end else if (r_q.main_pll_en && main_pll_lock) begin
                    r_d.state = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!main_pll_lock) begin
                    r_d.state = ST_MAIN_LOCK_WAIT;
                end else if (settle_done) begin
                    r_d.state       = ST_RUN;
                    r_d.clk_sel_pll = 1'b1;
                    r_d.restore_cpu = 1'b1;
                end
            end
            ST_RUN: begin
                if (sleep_req) r_d = SEQ_ASLEEP;
            end
            default: r_d = SEQ_ASLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_ASLEEP;
        else        r_q <= r_d;
    end

    assign osc_en         = r_q.osc_en;
    assign usb_pll_en     = r_q.usb_pll_en;
    assign main_pll_en    = r_q.main_pll_en;
    assign irq_mask       = r_q.irq_mask;
    assign clk_sel_pll    = r_q.clk_sel_pll;
    assign idle_cfg_clr   = r_q.idle_cfg_clr;
    assign restore_clkgen = r_q.restore_clkgen;
    assign restore_cpu    = r_q.restore_cpu;

    // R1: the oscillator only starts when a wake input was held
    a_r1_wake_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> $past(|wake_vec));

    // R3: the secondary PLL is enabled only after the oscillator reported ready
    a_r3_usb_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_pll_en) |-> $past(osc_ready) && $past(osc_en));

    // R4: interrupts unmask only after the secondary PLL lock was seen
    a_r4_mask_until_usb_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_mask) |-> $past(usb_pll_lock) && $past(usb_pll_en));

    // R5: the idle configuration clear precedes the main clock release
    a_r5_clear_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_pll_en) |-> $past(idle_cfg_clr));

    // R5: the clear is a single-cycle pulse
    a_r5_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cfg_clr |=> !idle_cfg_clr);

    // R6: leaving bypass needs the main PLL locked at the preceding edge
    a_r6_switch_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_pll) |-> $past(main_pll_lock) && $past(settle_done));

    // R7: a lock drop during settle keeps the clock in bypass
    a_r7_lock_loss_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETTLE && !main_pll_lock) |=>
            (!clk_sel_pll && r_q.state == ST_MAIN_LOCK_WAIT));

    // R10: wake inputs do not disturb a running sequencer
    a_r10_run_ignores_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && !sleep_req) |=> (r_q.state == ST_RUN && $stable(clk_sel_pll)));

endmodule

// File: tb/osc_wake_seq_bench.sv
module osc_wake_seq_bench;

    localparam int MIN_W  = 6;
    localparam int KHZ    = 20;
    localparam int US     = 1000;
    localparam int SETTLE = KHZ * US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic w_hw = 0, w_usb = 0, w_rtc = 0, w_ext = 0;
    logic osc_rdy = 0, usb_lk = 0, main_lk = 0, slp = 0;
    logic osc_en, usb_pll_en, main_pll_en, irq_mask, clk_sel_pll;
    logic idle_cfg_clr, restore_clkgen, restore_cpu;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    osc_wake_seq #(
        .MIN_WAKE_CYC (MIN_W),
        .BYPASS_KHZ   (KHZ),
        .SETTLE_US    (US)
    ) u_osc_wake_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .wake_hw_reset  (w_hw),
        .wake_usb_resume(w_usb),
        .wake_rtc_irq   (w_rtc),
        .wake_ext_irq   (w_ext),
        .osc_ready      (osc_rdy),
        .usb_pll_lock   (usb_lk),
        .main_pll_lock  (main_lk),
        .sleep_req      (slp),
        .osc_en         (osc_en),
        .usb_pll_en     (usb_pll_en),
        .main_pll_en    (main_pll_en),
        .irq_mask       (irq_mask),
        .clk_sel_pll    (clk_sel_pll),
        .idle_cfg_clr   (idle_cfg_clr),
        .restore_clkgen (restore_clkgen),
        .restore_cpu    (restore_cpu)
    );

    // behavioural reference: phase 0 asleep, 1 osc, 2 usb wait, 3 main wait, 4 settle, 5 run
    int phase = 0, held = 0, settled = 0;
    bit m_osc = 0, m_usb = 0, m_main = 0, m_mask = 1, m_sel = 0, m_clr = 0, m_cg = 0, m_cpu = 0;

    task automatic model_sleep();
        phase = 0; held = 0; settled = 0;
        m_osc = 0; m_usb = 0; m_main = 0; m_mask = 1;
        m_sel = 0; m_clr = 0; m_cg = 0; m_cpu = 0;
    endtask

    always @(posedge clk) begin
        bit was_clr;
        was_clr = m_clr;
        m_clr = 0;
        if (!rst_n) model_sleep();
        else begin
            case (phase)
                0: if (w_hw || w_usb || w_rtc || w_ext) begin
                       if (held >= MIN_W - 1) begin phase = 1; m_osc = 1; held = 0; end
                       else held++;
                   end else held = 0;
                1: if (osc_rdy) begin phase = 2; m_usb = 1; end
                2: if (usb_lk) begin phase = 3; m_mask = 0; m_clr = 1; end
                3: if (was_clr) begin m_main = 1; m_cg = 1; end
                   else if (m_main && main_lk) begin phase = 4; settled = 0; end
                4: if (!main_lk) phase = 3;
                   else if (settled == SETTLE - 1) begin phase = 5; m_sel = 1; m_cpu = 1; end
                   else settled++;
                5: if (slp) model_sleep();
                default: model_sleep();
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 osc_en", osc_en, m_osc);
            check("R3 usb_pll_en", usb_pll_en, m_usb);
            check("R4 irq_mask", irq_mask, m_mask);
            check("R5 idle_cfg_clr", idle_cfg_clr, m_clr);
            check("R5 main_pll_en", main_pll_en, m_main);
            check("R5 restore_clkgen", restore_clkgen, m_cg);
            check("R6 clk_sel_pll", clk_sel_pll, m_sel);
            check("R6 restore_cpu", restore_cpu, m_cpu);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_sleep();
        {w_hw, w_usb, w_rtc, w_ext, osc_rdy, usb_lk, main_lk, slp} = '0;
        cycles(3);
        rst_n = 1;
    endtask

    task automatic wait_for_main_en();
        while (!main_pll_en) @(negedge clk);
    endtask

    task automatic check_asleep(input string tag);
        check({tag, " irq_mask"}, irq_mask, 1);
        check({tag, " outputs"}, {osc_en, usb_pll_en, main_pll_en, clk_sel_pll,
                                  idle_cfg_clr, restore_clkgen, restore_cpu}, 0);
    endtask

    initial begin
        do_reset();
        cycles(2);
        check_asleep("R2 after reset");

        // R1: a pulse one edge short of the qualifying length is ignored
        w_ext = 1; cycles(MIN_W - 1); w_ext = 0;
        cycles(8);
        check("R1 short pulse", osc_en, 0);
        check_asleep("R1 short pulse");

        // R1: exactly the qualifying length starts the oscillator
        w_rtc = 1; cycles(MIN_W); w_rtc = 0;
        check("R1 qualified wake", osc_en, 1);

        // R3: no secondary PLL enable without oscillator ready
        cycles(5);
        check("R3 waiting for osc", usb_pll_en, 0);
        osc_rdy = 1;
        cycles(1);
        check("R3 usb enabled", usb_pll_en, 1);

        // R4: still masked before the secondary lock
        cycles(6);
        check("R4 masked before lock", irq_mask, 1);
        usb_lk = 1;
        cycles(1);
        check("R5 clear pulse", idle_cfg_clr, 1);
        check("R5 unmasked", irq_mask, 0);
        check("R5 main not yet", main_pll_en, 0);
        cycles(1);
        check("R5 main enabled", main_pll_en, 1);
        check("R5 clear ended", idle_cfg_clr, 0);

        // R9: exact settle length from the first sampled lock
        cycles(3);
        main_lk = 1;
        cycles(SETTLE);
        check("R9 still bypass", clk_sel_pll, 0);
        cycles(1);
        check("R9 switched", clk_sel_pll, 1);
        check("R6 cpu restored", restore_cpu, 1);

        // R10: a wake while running has no effect
        w_usb = 1; cycles(MIN_W + 4); w_usb = 0;
        cycles(2);
        check("R10 still running", clk_sel_pll, 1);
        check("R10 osc kept", osc_en, 1);

        // R8: sleep request returns to the sleep values
        slp = 1; cycles(1); slp = 0;
        check_asleep("R8 after sleep");
        {osc_rdy, usb_lk, main_lk} = '0;

        // R7: lock drop in the middle of settle restarts the count
        cycles(3);
        w_usb = 1; cycles(MIN_W + 2); w_usb = 0;
        osc_rdy = 1; cycles(3);
        usb_lk = 1;
        wait_for_main_en();
        main_lk = 1;
        cycles(SETTLE / 2);
        main_lk = 0;
        cycles(2);
        check("R7 bypass held", clk_sel_pll, 0);
        main_lk = 1;
        cycles(SETTLE);
        check("R7 full restart", clk_sel_pll, 0);
        cycles(1);
        check("R7 switched after restart", clk_sel_pll, 1);

        slp = 1; cycles(1); slp = 0;
        {osc_rdy, usb_lk, main_lk} = '0;

        // R4: secondary lock never arrives, interrupts stay masked
        cycles(2);
        w_hw = 1; cycles(MIN_W + 2); w_hw = 0;
        osc_rdy = 1;
        cycles(60);
        check("R4 never locked mask", irq_mask, 1);
        check("R4 never locked main", main_pll_en, 0);
        check("R4 usb enabled", usb_pll_en, 1);

        do_reset();
        cycles(2);
        check_asleep("R2 second reset");
        finish_run();
    end

endmodule